// File: doc/BRIEF.md
# Remappable CPU Address Window Decoder

This block holds a bank of programmable decode windows that steer CPU physical accesses to device targets. Each window has a base, a size in 64 KiB units, a 4-bit target ID, an 8-bit attribute and an enable. The lower-numbered windows can also translate the address to a different region. The address lookup is 36 bits wide. A lookup strobe returns a hit flag, the target, the attribute and the translated address one cycle later. When several windows match, the lowest-numbered one wins.

Software configures the windows through a 32-bit word register port. The map is irregular. The first eight windows use a 16-byte stride and each has four registers. A 16-byte gap follows at 0x80. Every window from 8 upward uses an 8-byte stride and has only the control and base registers.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every window is disabled, every register reads zero and all lookup outputs are zero.
- R2: The control register of a window keeps enable in bit 0, target in bits 7:4, attribute in bits 15:8 and size-minus-one (in 64 KiB units) in bits 31:16. Its other bits read zero.
- R3: The base register keeps address bits 31:16 in its bits 31:16 and address bits 35:32 in its bits 3:0. Its other bits read zero.
- R4: Window n below 8 sits at byte offset n*16, with control at +0, base at +4, remap-low at +8 and remap-high at +0xC. Window n of 8 or more sits at 0x90+(n-8)*8, with control at +0 and base at +4.
- R5: The following offsets read zero and ignore writes: the gap 0x80-0x8F, offsets past the last window, and the remap offsets of windows that cannot remap.
- R6: An enabled window matches address a when base <= a < base + size, with size = (ctrl[31:16]+1)*65536.
- R7: A window with enable clear never matches, whatever its base and size.
- R8: For a hit on a window whose index is below the remap count, the output address is {remap_hi[3:0], remap_lo[31:16], 16'h0} OR (a AND (size-1)). Remap-low keeps bits 31:16 and remap-high keeps bits 3:0; all other bits read zero.
- R9: For a hit on a window at or above the remap count, the output address equals the input address.
- R10: When several enabled windows match, the lowest-numbered window supplies the target, attribute and address.
- R11: When no window matches, hit, target, attribute and output address are all zero.
- R12: A strobe in cycle t gives valid and its result in cycle t+1. Valid is low in any cycle after a cycle with no strobe, and the result outputs hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | ADDR_W (8) | Register byte offset; bits 1:0 are ignored |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_addr_i | input | 36 | Physical address to decode |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | A window matched |
| lk_target_o | output | 4 | Target ID of the winning window |
| lk_attr_o | output | 8 | Attribute of the winning window |
| lk_addr_o | output | 36 | Translated or passed-through address |

## Verification
The hardest case to reach is a pair of enabled windows that overlap, checked at the exact byte where the lower window's range ends and the higher one's continues. The lower window must win inside its range and lose one address later. The stimulus sets up a 64 KiB high-stride window inside a 1 MiB window with a larger index. It then probes addresses on both sides of that edge, probes the first and last byte of a 128 KiB remapped window and the address just past it, and probes a disabled window before and after its enable bit is set.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int PA_W        = 36;
  localparam int GRAN_W      = 16;
  localparam int PAGE_W      = PA_W - GRAN_W;
  localparam int WIDE_WIN    = 8;
  localparam int NARROW_BASE = 'h90;

  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_BASE = 2'd1,
    FLD_RMLO = 2'd2,
    FLD_RMHI = 2'd3
  } fld_e;

  typedef struct packed {
    logic              en;
    logic [3:0]        tgt;
    logic [7:0]        attr;
    logic [15:0]       size_m1;
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] remap;
  } win_cfg_t;
endpackage

// File: rtl/awd_regs.sv
module awd_regs
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int ADDR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output win_cfg_t          cfg_o [NUM_WIN]
);
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  int         offs;
  int         dec_win;
  logic       dec_ok;
  fld_e       dec_fld;
  logic [IDX_W-1:0] dec_idx;

  always_comb begin
    offs    = int'(addr_i);
    dec_win = 0;
    dec_fld = FLD_CTRL;
    dec_ok  = 1'b0;
    if (offs < WIDE_WIN * 16) begin
      dec_win = offs >> 4;
      dec_fld = fld_e'(offs[3:2]);
      dec_ok  = (dec_win < NUM_WIN) && ((dec_win < NUM_REMAP) || !dec_fld[1]);
    end else if (offs >= NARROW_BASE) begin
      dec_win = WIDE_WIN + ((offs - NARROW_BASE) >> 3);
      dec_fld = fld_e'({1'b0, offs[2]});
      dec_ok  = dec_win < NUM_WIN;
    end
    dec_idx = IDX_W'(dec_win);
  end

  win_cfg_t cfg_q [NUM_WIN];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[i] <= '0;
      end else if (we_i && dec_ok && dec_idx == IDX_W'(i)) begin
        unique case (dec_fld)
          FLD_CTRL: begin
            cfg_q[i].en      <= wdata_i[0];
            cfg_q[i].tgt     <= wdata_i[7:4];
            cfg_q[i].attr    <= wdata_i[15:8];
            cfg_q[i].size_m1 <= wdata_i[31:16];
          end
          FLD_BASE: cfg_q[i].base <= {wdata_i[3:0], wdata_i[31:16]};
          FLD_RMLO: cfg_q[i].remap[15:0] <= wdata_i[31:16];
          FLD_RMHI: cfg_q[i].remap[PAGE_W-1:16] <= wdata_i[3:0];
          default: ;
        endcase
      end
    end
    assign cfg_o[i] = cfg_q[i];
  end

  win_cfg_t sel;
  always_comb begin
    sel     = cfg_q[dec_idx];
    rdata_o = '0;
    if (dec_ok) begin
      unique case (dec_fld)
        FLD_CTRL: rdata_o = {sel.size_m1, sel.attr, sel.tgt, 3'b0, sel.en};
        FLD_BASE: rdata_o = {sel.base[15:0], 12'b0, sel.base[PAGE_W-1:16]};
        FLD_RMLO: rdata_o = {sel.remap[15:0], 16'b0};
        FLD_RMHI: rdata_o = {28'b0, sel.remap[PAGE_W-1:16]};
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8
) (
  input  win_cfg_t            cfg_i  [NUM_WIN],
  input  logic [PA_W-1:0]     addr_i,
  output logic [NUM_WIN-1:0]  hit_o,
  output logic [PA_W-1:0]     xlat_o [NUM_WIN]
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    logic [PA_W:0]   lo, hi, a_ext;
    logic [PA_W-1:0] off_mask;
    // Compare in PA_W+1 bits so a window that ends at the top of the space does not wrap
    assign a_ext    = {1'b0, addr_i};
    assign lo       = {1'b0, cfg_i[i].base, {GRAN_W{1'b0}}};
    assign hi       = lo + {{(PA_W+1-GRAN_W-16){1'b0}}, cfg_i[i].size_m1, {GRAN_W{1'b0}}}
                         + (PA_W+1)'(1 << GRAN_W);
    assign off_mask = {{(PAGE_W-16){1'b0}}, cfg_i[i].size_m1, {GRAN_W{1'b1}}};
    assign hit_o[i] = cfg_i[i].en && (a_ext >= lo) && (a_ext < hi);
    if (i < NUM_REMAP) begin : g_remap
      assign xlat_o[i] = {cfg_i[i].remap, {GRAN_W{1'b0}}} | (addr_i & off_mask);
    end else begin : g_pass
      assign xlat_o[i] = addr_i;
    end
  end
endmodule

// File: rtl/awd_prio_pick.sv
module awd_prio_pick
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 20
) (
  input  logic [NUM_WIN-1:0] hit_i,
  input  logic [PA_W-1:0]    xlat_i [NUM_WIN],
  input  win_cfg_t           cfg_i  [NUM_WIN],
  output logic               hit_o,
  output logic [3:0]         tgt_o,
  output logic [7:0]         attr_o,
  output logic [PA_W-1:0]    addr_o
);
  // Walk from the top down so the lowest matching index is applied last
  always_comb begin
    hit_o  = 1'b0;
    tgt_o  = '0;
    attr_o = '0;
    addr_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        hit_o  = 1'b1;
        tgt_o  = cfg_i[i].tgt;
        attr_o = cfg_i[i].attr;
        addr_o = xlat_i[i];
      end
    end
  end
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  localparam int LAST_OFF = (NUM_WIN > WIDE_WIN) ? NARROW_BASE + (NUM_WIN - WIDE_WIN) * 8
                                                 : NUM_WIN * 16,
  localparam int ADDR_W   = $clog2(LAST_OFF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              lk_valid_i,
  input  logic [35:0]       lk_addr_i,
  output logic              lk_valid_o,
  output logic              lk_hit_o,
  output logic [3:0]        lk_target_o,
  output logic [7:0]        lk_attr_o,
  output logic [35:0]       lk_addr_o
);
  win_cfg_t             cfg [NUM_WIN];
  logic [NUM_WIN-1:0]   hit_vec;
  logic [PA_W-1:0]      xlat [NUM_WIN];
  logic                 pick_hit;
  logic [3:0]           pick_tgt;
  logic [7:0]           pick_attr;
  logic [PA_W-1:0]      pick_addr;

  awd_regs #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  awd_win_match #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_match (
    .cfg_i  (cfg),
    .addr_i (lk_addr_i),
    .hit_o  (hit_vec),
    .xlat_o (xlat)
  );

  awd_prio_pick #(.NUM_WIN(NUM_WIN)) u_pick (
    .hit_i  (hit_vec),
    .xlat_i (xlat),
    .cfg_i  (cfg),
    .hit_o  (pick_hit),
    .tgt_o  (pick_tgt),
    .attr_o (pick_attr),
    .addr_o (pick_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o  <= 1'b0;
      lk_hit_o    <= 1'b0;
      lk_target_o <= '0;
      lk_attr_o   <= '0;
      lk_addr_o   <= '0;
    end else begin
      lk_valid_o <= lk_valid_i;
      if (lk_valid_i) begin
        lk_hit_o    <= pick_hit;
        lk_target_o <= pick_tgt;
        lk_attr_o   <= pick_attr;
        lk_addr_o   <= pick_addr;
      end
    end
  end
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_rdata_o,
  input logic              lk_valid_i,
  input logic              lk_valid_o,
  input logic              lk_hit_o,
  input logic [3:0]        lk_target_o,
  input logic [7:0]        lk_attr_o,
  input logic [35:0]       lk_addr_o
);
  AST_STROBE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_valid_o); // R12

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !lk_valid_o); // R12

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> ($stable(lk_hit_o) && $stable(lk_target_o)
                     && $stable(lk_attr_o) && $stable(lk_addr_o))); // R12

  AST_MISS_ZEROED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && !lk_hit_o) |-> (lk_target_o == '0 && lk_attr_o == '0
                                    && lk_addr_o == '0)); // R11

  AST_GAP_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(reg_addr_i) >= 'h80 && int'(reg_addr_i) < 'h90) |-> reg_rdata_o == '0); // R5
endmodule

bind addr_win_decoder awd_checker #(.ADDR_W(ADDR_W)) u_awd_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .lk_valid_i  (lk_valid_i),
  .lk_valid_o  (lk_valid_o),
  .lk_hit_o    (lk_hit_o),
  .lk_target_o (lk_target_o),
  .lk_attr_o   (lk_attr_o),
  .lk_addr_o   (lk_addr_o)
);

// File: tb/addr_win_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_win_decoder_tb_top;
  localparam int NW = 20;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  raddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lv = 1'b0;
  logic [35:0] la = '0;
  logic        ov, oh;
  logic [3:0]  ot;
  logic [7:0]  oa;
  logic [35:0] oaddr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  addr_win_decoder #(.NUM_WIN(NW), .NUM_REMAP(NR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lk_valid_i(lv), .lk_addr_i(la),
    .lk_valid_o(ov), .lk_hit_o(oh), .lk_target_o(ot), .lk_attr_o(oa), .lk_addr_o(oaddr)
  );

  // behavioural register image
  logic [31:0] m_ctrl [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_rlo  [NW];
  logic [31:0] m_rhi  [NW];
  initial for (int i = 0; i < NW; i++) begin
    m_ctrl[i] = 0; m_base[i] = 0; m_rlo[i] = 0; m_rhi[i] = 0;
  end

  function automatic bit mdec(input int o, output int w, output int f);
    w = 0; f = 0;
    if (o < 128) begin
      w = o / 16; f = (o % 16) / 4;
      return (w < NW) && (f < 2 || w < NR);
    end
    if (o < 'h90) return 0;
    w = 8 + (o - 'h90) / 8; f = (o % 8) / 4;
    return w < NW;
  endfunction

  function automatic logic [31:0] mread(input int o);
    int w, f;
    if (!mdec(o, w, f)) return 0;
    case (f)
      0: return m_ctrl[w] & 32'hFFFF_FFF1;
      1: return m_base[w] & 32'hFFFF_000F;
      2: return m_rlo[w] & 32'hFFFF_0000;
      default: return m_rhi[w] & 32'h0000_000F;
    endcase
  endfunction

  task automatic mwrite(input int o, input logic [31:0] d);
    int w, f;
    if (!mdec(o, w, f)) return;
    case (f)
      0: m_ctrl[w] = d;
      1: m_base[w] = d;
      2: m_rlo[w] = d;
      default: m_rhi[w] = d;
    endcase
  endtask

  // {hit, tgt, attr, addr}
  function automatic logic [48:0] mlook(input logic [35:0] a);
    longint aa, b, sz, rm;
    aa = longint'({28'b0, a});
    for (int w = 0; w < NW; w++) begin
      if (m_ctrl[w][0]) begin
        b  = (longint'({32'b0, m_base[w]}) & 'hF) * 64'h1_0000_0000
             + (longint'({32'b0, m_base[w]}) & 'hFFFF_0000);
        sz = (longint'({48'b0, m_ctrl[w][31:16]}) + 1) * 65536;
        if (aa >= b && aa < b + sz) begin
          if (w < NR) begin
            rm = (longint'({32'b0, m_rhi[w]}) & 'hF) * 64'h1_0000_0000
                 + (longint'({32'b0, m_rlo[w]}) & 'hFFFF_0000);
            aa = rm | (aa & (sz - 1));
          end
          return {1'b1, m_ctrl[w][7:4], m_ctrl[w][15:8], aa[35:0]};
        end
      end
    end
    return '0;
  endfunction

  string cur_tag = "R1";
  string exp_tag = "R1";
  logic        e_v = 0, e_h = 0;
  logic [3:0]  e_t = 0;
  logic [7:0]  e_a = 0;
  logic [35:0] e_ad = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_v <= 0; e_h <= 0; e_t <= 0; e_a <= 0; e_ad <= 0; exp_tag <= "R1";
    end else begin
      e_v <= lv;
      exp_tag <= lv ? cur_tag : "R12";
      if (lv) {e_h, e_t, e_a, e_ad} <= mlook(la);
    end
  end

  always @(negedge clk) if (!done) begin
    n_cmp++;
    if ({ov, oh, ot, oa, oaddr} !== {e_v, e_h, e_t, e_a, e_ad}) begin
      n_bad++;
      $display("FAIL %s lookup: got v=%0b h=%0b t=%h a=%h addr=%h exp v=%0b h=%0b t=%h a=%h addr=%h",
               exp_tag, ov, oh, ot, oa, oaddr, e_v, e_h, e_t, e_a, e_ad);
    end
  end

  task automatic wr(input int o, input logic [31:0] d);
    @(negedge clk);
    we = 1; raddr = 8'(o); wdata = d;
    @(posedge clk); #1;
    mwrite(o, d);
    we = 0;
  endtask

  task automatic rd_chk(input int o, input string tag);
    @(negedge clk);
    raddr = 8'(o);
    #1;
    n_cmp++;
    if (rdata !== mread(o)) begin
      n_bad++;
      $display("FAIL %s read @%h: got %h exp %h", tag, o, rdata, mread(o));
    end
  endtask

  task automatic look(input logic [35:0] a, input string tag);
    @(negedge clk);
    cur_tag = tag; lv = 1; la = a;
    @(negedge clk);
    lv = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: registers empty after reset
    rd_chk('h00, "R1"); rd_chk('h94, "R1"); rd_chk('h0C, "R1");
    look(36'h0_0000_0000, "R1");
    // R2 R3 R8 R4: field masks on window 0 and window 8
    wr('h00, 32'hFFFF_FFFF); rd_chk('h00, "R2");
    wr('h04, 32'hFFFF_FFFF); rd_chk('h04, "R3");
    wr('h08, 32'hFFFF_FFFF); rd_chk('h08, "R8");
    wr('h0C, 32'hFFFF_FFFF); rd_chk('h0C, "R8");
    wr('h90, 32'h1234_5671); rd_chk('h90, "R4"); rd_chk('h00, "R4");
    wr('h74, 32'hABCD_0005); rd_chk('h74, "R4"); rd_chk('h64, "R4");
    // R5: gap and past-end offsets
    wr('h84, 32'hFFFF_FFFF); rd_chk('h84, "R5"); rd_chk('h80, "R5");
    wr('hF0, 32'hFFFF_FFFF); rd_chk('hF0, "R5"); rd_chk('hE8, "R5");
    rd_chk('h90, "R5"); rd_chk('h7C, "R5");
    // clear windows used above
    wr('h00, 0); wr('h90, 0); wr('h74, 0);
    // window 2: tgt 5, attr E0, 128K at 0x3_0002_0000, remap 0x1_8000_0000
    wr('h24, 32'h0002_0003); wr('h28, 32'h8000_0000); wr('h2C, 32'h1);
    wr('h20, 32'h0001_E051); rd_chk('h20, "R4");
    // window 9: tgt 8, attr 70, 64K at 0x4000_0000
    wr('h9C, 32'h4000_0000); wr('h98, 32'h0000_7081);
    // window 12: tgt 1, attr 2F, 1M at 0x4000_0000
    wr('hB4, 32'h4000_0000); wr('hB0, 32'h000F_2F11);
    // window 5: disabled, 64K at 0x5000_0000
    wr('h54, 32'h5000_0000); wr('h50, 32'h0000_3360);
    look(36'h3_0002_0000, "R6");
    look(36'h3_0003_FFFF, "R8");
    look(36'h3_0002_1234, "R8");
    look(36'h3_0004_0000, "R11");
    look(36'h3_0001_FFFF, "R6");
    look(36'h0_4000_1234, "R9");
    look(36'h0_4000_FFFF, "R10");
    look(36'h0_4001_0000, "R10");
    look(36'h0_400F_FFFF, "R6");
    look(36'h0_4010_0000, "R11");
    look(36'h0_5000_0000, "R7");
    repeat (4) @(negedge clk); // R12 hold window
    wr('h50, 32'h0000_3361);
    look(36'h0_5000_8000, "R7");
    // R12: back-to-back strobes
    @(negedge clk); cur_tag = "R12"; lv = 1; la = 36'h3_0002_0010;
    @(negedge clk); la = 36'h0_4000_0020;
    @(negedge clk); la = 36'hF_FFFF_0000;
    @(negedge clk); lv = 0;
    repeat (3) @(negedge clk);
    // R1: reset mid-run clears everything
    rst_n = 0;
    for (int i = 0; i < NW; i++) begin
      m_ctrl[i] = 0; m_base[i] = 0; m_rlo[i] = 0; m_rhi[i] = 0;
    end
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd_chk('h20, "R1"); rd_chk('hB0, "R1");
    look(36'h3_0002_0000, "R1");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule